// File: doc/BRIEF.md
# Four-State Invalidating Snoop Cache Controller

This block is the private cache of one processor on a shared broadcast bus. It holds a small direct-mapped write-back cache. Every line carries one of four coherence states: invalid, shared-clean, exclusive-clean or modified (dirty and exclusive). The processor issues byte reads and writes on its request port. When a request needs the bus, the controller stalls the processor with a busy flag. It then runs the bus work in order: first a write-back of a dirty victim, then the fetch of the new line, or an address-only invalidation when the processor writes a shared line.

A second port watches the transactions of the other bus masters. The tag and state directory has two independent read ports, so a snooped address is looked up in the same cycle as a processor access and never waits for it. On a snoop hit the cache reports that it holds the line. It also offers the line data when its copy is dirty, so that the bus can refresh memory and serve the requester. The state then drops to shared-clean after a plain read, or to invalid after an exclusive read or an invalidation.

With the default parameters the cache has 8 lines of 8 bytes and uses a 10-bit byte address. The byte address splits into a 4-bit tag in bits 9..7, 6, a 3-bit index in bits 5..3 and a 3-bit byte offset in bits 2..0.

Top module: `snoop_cache`

## Requirements
- R1: After reset every line is invalid, and cpu_ack, cpu_busy and bus_req are low. The first access to any address therefore misses.
- R2: On a read miss the line address (byte address bits 9..3) is sent with command 0 (read). If bus_shared is low when bus_done arrives, the line is installed exclusive-clean. Line byte k sits in bits 8k+7..8k of the line bus.
- R3: If bus_shared is high when a read fill completes, the line is installed shared-clean.
- R4: A write that hits an exclusive-clean or modified line completes with no bus transaction and leaves the line modified.
- R5: A write that hits a shared-clean line first issues command 2 (address-only invalidate) for that line. The write then completes and the line is modified.
- R6: A write miss fetches the line with command 1 (read-exclusive), then writes the byte and leaves the line modified.
- R7: When a miss displaces a modified line, the controller first issues command 3 (write-back). This carries the old line address and the full old line data. The fetch of the new line starts only after that write-back has completed.
- R8: When a miss displaces a line that is invalid, shared-clean or exclusive-clean, no write-back is issued.
- R9: A snoop that hits a valid line raises snp_shared in the same cycle. If the line is modified it also raises snp_dirty and drives the line on snp_data. A snooped read (snp_cmd 0) leaves the line shared-clean.
- R10: A snooped read-exclusive (1) or invalidate (2) that hits a line makes it invalid, so the next processor access to it misses.
- R11: A snoop whose tag does not match keeps snp_shared and snp_dirty low and changes no line.
- R12: A request that can finish without the bus raises cpu_ack in the same cycle, with read data on cpu_rdata. cpu_busy stays high while a request is waiting. A request whose index equals a snoop's index in the same cycle waits one cycle, and the snoop is applied first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 10 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid with cpu_ack |
| cpu_ack | output | 1 | Request completes this cycle |
| cpu_busy | output | 1 | Request pending and not completing |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 invalidate, 3 write-back |
| bus_addr | output | 7 | Line address of the transaction |
| bus_wdata | output | 64 | Line data for write-back |
| bus_done | input | 1 | One-cycle completion pulse |
| bus_rdata | input | 64 | Fill line, valid with bus_done |
| bus_shared | input | 1 | Another cache holds the line, valid with bus_done |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | 7 | Snooped line address |
| snp_shared | output | 1 | Snoop hit a valid line |
| snp_dirty | output | 1 | Snoop hit a modified line |
| snp_data | output | 64 | Line data of the snooped index |

## Verification
Processor access patterns are sent through a behavioural model with its own state, memory and "other cache" presence table. The patterns are: repeated hits to one line, a write to an exclusive line against a write to a shared line, fills with bus_shared high and low, and conflicting tags on one index with dirty and clean victims. Each pattern yields a different expected order of bus commands. A silent upgrade, a missing invalidate and a skipped or misplaced write-back each show up as a mismatch in that order. Snoops of each command are applied to modified, shared and absent lines. The next processor access then shows whether the state dropped. A snoop and a processor access aimed at the same index in the same cycle test the collision ordering. A long mixed sweep follows the directed cases.

// File: rtl/snoop_pkg.sv
`timescale 1ns/1ps
package snoop_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BUS_RD  = 2'd0,
    BUS_RDX = 2'd1,
    BUS_INV = 2'd2,
    BUS_WB  = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/sc_dir.sv
`timescale 1ns/1ps
module sc_dir
  import snoop_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cpu_idx,
  output logic [TAG_W-1:0] cpu_tag_o,
  output line_st_t         cpu_st_o,
  input  logic [IDX_W-1:0] snp_idx,
  output logic [TAG_W-1:0] snp_tag_o,
  output line_st_t         snp_st_o,
  input  logic             upd_en,
  input  logic [TAG_W-1:0] upd_tag,
  input  line_st_t         upd_st,
  input  logic             snp_upd_en,
  input  line_st_t         snp_upd_st
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  line_st_t         st_q  [LINES];

  // two independent read ports
  assign cpu_tag_o = tag_q[cpu_idx];
  assign cpu_st_o  = st_q[cpu_idx];
  assign snp_tag_o = tag_q[snp_idx];
  assign snp_st_o  = st_q[snp_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= LS_INV;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (snp_upd_en && snp_idx == IDX_W'(i)) begin
          st_q[i] <= snp_upd_st;
        end else if (upd_en && cpu_idx == IDX_W'(i)) begin
          st_q[i]  <= upd_st;
          tag_q[i] <= upd_tag;
        end
      end
    end
  end

  AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_upd_en |=> st_q[$past(snp_idx)] == $past(snp_upd_st)); // R10
endmodule

// File: rtl/sc_data.sv
`timescale 1ns/1ps
module sc_data #(
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [(DATA_W<<OFF_W)-1:0] a_line,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [(DATA_W<<OFF_W)-1:0] b_line,
  input  logic              fill_we,
  input  logic [(DATA_W<<OFF_W)-1:0] fill_line,
  input  logic              byte_we,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] byte_in
);
  localparam int LINES  = 1 << IDX_W;
  localparam int LINE_W = DATA_W << OFF_W;

  logic [LINE_W-1:0] line_q [LINES];

  assign a_line = line_q[a_idx];
  assign b_line = line_q[b_idx];

  // data storage carries no reset; validity lives in the directory
  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (a_idx == IDX_W'(i)) begin
        if (fill_we) begin
          line_q[i] <= fill_line;
        end else if (byte_we) begin
          line_q[i][int'(off)*DATA_W +: DATA_W] <= byte_in;
        end
      end
    end
  end
endmodule

// File: rtl/sc_ctrl.sv
`timescale 1ns/1ps
module sc_ctrl
  import snoop_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cpu_req,
  input  logic     cpu_we,
  input  logic     tag_hit,
  input  line_st_t line_st,
  input  logic     collide,
  input  logic     bus_done,
  input  logic     bus_shared,
  output logic     cpu_ack,
  output logic     bus_req,
  output bus_cmd_t bus_cmd,
  output logic     victim_sel,
  output logic     dir_we,
  output line_st_t dir_st,
  output logic     byte_we,
  output logic     fill_we
);
  typedef enum logic [1:0] {CS_IDLE, CS_WB, CS_FILL, CS_UPG} ctl_st_t;

  ctl_st_t st_q, st_d;

  always_comb begin
    st_d       = st_q;
    cpu_ack    = 1'b0;
    bus_req    = 1'b0;
    bus_cmd    = BUS_RD;
    victim_sel = 1'b0;
    dir_we     = 1'b0;
    dir_st     = LS_INV;
    byte_we    = 1'b0;
    fill_we    = 1'b0;
    case (st_q)
      CS_IDLE: begin
        if (cpu_req && !collide) begin
          if (tag_hit) begin
            if (!cpu_we) begin
              cpu_ack = 1'b1;
            end else if (line_st == LS_EXC || line_st == LS_MOD) begin
              cpu_ack = 1'b1;
              byte_we = 1'b1;
              dir_we  = 1'b1;
              dir_st  = LS_MOD;
            end else begin
              st_d = CS_UPG;
            end
          end else begin
            st_d = (line_st == LS_MOD) ? CS_WB : CS_FILL;
          end
        end
      end
      CS_WB: begin
        victim_sel = 1'b1;
        bus_cmd    = BUS_WB;
        if (line_st != LS_MOD) begin
          st_d = CS_FILL;
        end else begin
          bus_req = 1'b1;
          if (bus_done) st_d = CS_FILL;
        end
      end
      CS_FILL: begin
        bus_req = 1'b1;
        bus_cmd = cpu_we ? BUS_RDX : BUS_RD;
        if (bus_done) begin
          fill_we = 1'b1;
          dir_we  = 1'b1;
          dir_st  = (!cpu_we && bus_shared) ? LS_SHR : LS_EXC;
          st_d    = CS_IDLE;
        end
      end
      CS_UPG: begin
        bus_cmd = BUS_INV;
        if (!(tag_hit && line_st == LS_SHR)) begin
          st_d = CS_IDLE;
        end else begin
          bus_req = 1'b1;
          if (bus_done) begin
            dir_we = 1'b1;
            dir_st = LS_EXC;
            st_d   = CS_IDLE;
          end
        end
      end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CS_IDLE;
    else        st_q <= st_d;
  end

  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> !bus_req); // R4
  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> cpu_req); // R12
  AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == BUS_WB && !bus_done) |=> (bus_req && bus_cmd == BUS_WB)); // R7
  AST_FETCH_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == BUS_WB && bus_done) |=>
      (bus_req && (bus_cmd == BUS_RD || bus_cmd == BUS_RDX))); // R7
endmodule

// File: rtl/snoop_cache.sv
`timescale 1ns/1ps
module snoop_cache
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic [DATA_W-1:0]             cpu_rdata,
  output logic                          cpu_ack,
  output logic                          cpu_busy,
  output logic                          bus_req,
  output logic [1:0]                    bus_cmd,
  output logic [ADDR_W-OFF_W-1:0]       bus_addr,
  output logic [(DATA_W<<OFF_W)-1:0]    bus_wdata,
  input  logic                          bus_done,
  input  logic [(DATA_W<<OFF_W)-1:0]    bus_rdata,
  input  logic                          bus_shared,
  input  logic                          snp_valid,
  input  logic [1:0]                    snp_cmd,
  input  logic [ADDR_W-OFF_W-1:0]       snp_addr,
  output logic                          snp_shared,
  output logic                          snp_dirty,
  output logic [(DATA_W<<OFF_W)-1:0]    snp_data
);
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int TAG_W  = LA_W - IDX_W;
  localparam int LINE_W = DATA_W << OFF_W;

  // asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag, dir_cpu_tag, dir_snp_tag;
  logic [OFF_W-1:0] cpu_off;
  line_st_t         dir_cpu_st, dir_snp_st, ctl_dir_st, snp_new_st;
  logic             tag_hit, snp_hit, collide, snp_upd;
  logic             victim_sel, dir_we, byte_we, fill_we;
  bus_cmd_t         ctl_cmd, snp_kind;
  logic [LINE_W-1:0] line_a, line_b;

  assign cpu_off = cpu_addr[OFF_W-1:0];
  assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
  assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[LA_W-1 -: TAG_W];
  assign snp_kind = bus_cmd_t'(snp_cmd);

  sc_dir #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_dir (
    .clk        (clk),
    .rst_n      (rst_ni),
    .cpu_idx    (cpu_idx),
    .cpu_tag_o  (dir_cpu_tag),
    .cpu_st_o   (dir_cpu_st),
    .snp_idx    (snp_idx),
    .snp_tag_o  (dir_snp_tag),
    .snp_st_o   (dir_snp_st),
    .upd_en     (dir_we),
    .upd_tag    (cpu_tag),
    .upd_st     (ctl_dir_st),
    .snp_upd_en (snp_upd),
    .snp_upd_st (snp_new_st)
  );

  sc_data #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .a_idx     (cpu_idx),
    .a_line    (line_a),
    .b_idx     (snp_idx),
    .b_line    (line_b),
    .fill_we   (fill_we),
    .fill_line (bus_rdata),
    .byte_we   (byte_we),
    .off       (cpu_off),
    .byte_in   (cpu_wdata)
  );

  assign tag_hit = (dir_cpu_st != LS_INV) && (dir_cpu_tag == cpu_tag);
  assign collide = snp_valid && (snp_idx == cpu_idx);

  sc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_ni),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .tag_hit    (tag_hit),
    .line_st    (dir_cpu_st),
    .collide    (collide),
    .bus_done   (bus_done),
    .bus_shared (bus_shared),
    .cpu_ack    (cpu_ack),
    .bus_req    (bus_req),
    .bus_cmd    (ctl_cmd),
    .victim_sel (victim_sel),
    .dir_we     (dir_we),
    .dir_st     (ctl_dir_st),
    .byte_we    (byte_we),
    .fill_we    (fill_we)
  );

  assign cpu_rdata = line_a[int'(cpu_off)*DATA_W +: DATA_W];
  assign cpu_busy  = cpu_req && !cpu_ack;
  assign bus_cmd   = ctl_cmd;
  assign bus_addr  = victim_sel ? {dir_cpu_tag, cpu_idx} : {cpu_tag, cpu_idx};
  assign bus_wdata = line_a;

  // snoop side: lookup on its own directory port
  assign snp_hit    = snp_valid && (dir_snp_st != LS_INV) && (dir_snp_tag == snp_tag);
  assign snp_shared = snp_hit;
  assign snp_dirty  = snp_hit && (dir_snp_st == LS_MOD);
  assign snp_data   = line_b;
  assign snp_upd    = snp_hit && (snp_kind != BUS_WB);
  assign snp_new_st = (snp_kind == BUS_RD) ? LS_SHR : LS_INV;

  AST_SNP_DIRTY_VALID: assert property (@(posedge clk) disable iff (!rst_ni)
    snp_dirty |-> (snp_shared && snp_valid)); // R9
endmodule

// File: tb/tb_snoop_cache.sv
`timescale 1ns/1ps
module tb_snoop_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [9:0]  cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        cpu_ack, cpu_busy;
  logic        bus_req;
  logic [1:0]  bus_cmd;
  logic [6:0]  bus_addr;
  logic [63:0] bus_wdata, bus_rdata;
  logic        bus_done, bus_shared;
  logic        snp_valid;
  logic [1:0]  snp_cmd;
  logic [6:0]  snp_addr;
  logic        snp_shared, snp_dirty;
  logic [63:0] snp_data;

  always #5 clk = ~clk;

  snoop_cache dut (.*);

  int total = 0;
  int bad   = 0;
  string cur_rq = "R1";

  // responder memory and bench-side presence of the line in other caches
  logic [63:0] mem  [128];
  logic [63:0] emem [128];
  bit          other [128];
  // reference model of this cache
  int          mst  [8];
  logic [3:0]  mtag [8];
  logic [63:0] mdat [8];
  // expected bus transactions in order
  logic [1:0]  eq_cmd [$];
  logic [6:0]  eq_la  [$];
  logic [63:0] eq_dat [$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // behavioural bus and memory
  bit          in_tx = 0;
  int          lat   = 0;
  logic [1:0]  tx_cmd;
  logic [6:0]  tx_la;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_done) begin
        bus_done   = 1'b0;
        bus_shared = 1'b0;
        in_tx      = 0;
      end else if (bus_req) begin
        if (!in_tx) begin
          in_tx  = 1;
          lat    = 0;
          tx_cmd = bus_cmd;
          tx_la  = bus_addr;
          if (eq_cmd.size() == 0) begin
            chk(0, cur_rq, "unexpected bus command", 64'(bus_cmd), 64'hF);
          end else begin
            logic [1:0]  ec;
            logic [6:0]  ea;
            logic [63:0] ed;
            ec = eq_cmd.pop_front();
            ea = eq_la.pop_front();
            ed = eq_dat.pop_front();
            chk(bus_cmd == ec, cur_rq, "bus command", 64'(bus_cmd), 64'(ec));
            chk(bus_addr == ea, cur_rq, "bus line address", 64'(bus_addr), 64'(ea));
            if (ec == 2'd3)
              chk(bus_wdata == ed, cur_rq, "write-back data", bus_wdata, ed);
          end
        end
        lat++;
        if (lat >= 3) begin
          case (tx_cmd)
            2'd0: begin bus_rdata = mem[tx_la]; bus_shared = other[tx_la]; end
            2'd1: begin bus_rdata = mem[tx_la]; bus_shared = 1'b0; end
            2'd3: mem[tx_la] = bus_wdata;
            default: ;
          endcase
          bus_done = 1'b1;
        end
      end
    end
  end

  task automatic push_exp(input logic [1:0] c, input logic [6:0] la, input logic [63:0] d);
    eq_cmd.push_back(c);
    eq_la.push_back(la);
    eq_dat.push_back(d);
  endtask

  task automatic cpu_op(input bit we, input logic [9:0] a, input logic [7:0] wd,
                        input string rq);
    logic [6:0] la;
    logic [2:0] ix;
    logic [2:0] off;
    bit         hit, nob;
    logic [7:0] exp_rd;
    int         n;
    la  = a[9:3];
    ix  = la[2:0];
    off = a[2:0];
    hit = (mst[ix] != 0) && (mtag[ix] == la[6:3]);
    nob = 0;
    cur_rq = rq;
    if (hit) begin
      if (!we) nob = 1;
      else if (mst[ix] >= 2) begin nob = 1; mst[ix] = 3; end
      else begin push_exp(2'd2, la, '0); other[la] = 0; mst[ix] = 3; end
    end else begin
      if (mst[ix] == 3) begin
        push_exp(2'd3, {mtag[ix], ix}, mdat[ix]);
        emem[{mtag[ix], ix}] = mdat[ix];
      end
      push_exp(we ? 2'd1 : 2'd0, la, '0);
      mdat[ix] = emem[la];
      mtag[ix] = la[6:3];
      if (we) begin other[la] = 0; mst[ix] = 3; end
      else mst[ix] = other[la] ? 1 : 2;
    end
    if (we) mdat[ix][int'(off)*8 +: 8] = wd;
    exp_rd = mdat[ix][int'(off)*8 +: 8];

    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #2;
    if (!nob) chk(cpu_busy && !cpu_ack, "R12", "busy while waiting", 64'(cpu_busy), 64'd1);
    n = 0;
    while (!cpu_ack && n < 500) begin
      @(negedge clk); #2; n++;
    end
    chk(n < 500, rq, "request completes", 64'(n), 64'd0);
    if (nob) chk(n == 0, "R12", "bus-free request acks at once", 64'(n), 64'd0);
    if (!we) chk(cpu_rdata == exp_rd, rq, "read data", 64'(cpu_rdata), 64'(exp_rd));
    chk(eq_cmd.size() == 0, rq, "all expected bus commands seen", 64'(eq_cmd.size()), 64'd0);
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [6:0] la, input string rq);
    logic [2:0] ix;
    bit hit, dirty;
    ix    = la[2:0];
    hit   = (mst[ix] != 0) && (mtag[ix] == la[6:3]);
    dirty = hit && mst[ix] == 3;
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = la;
    #2;
    chk(snp_shared == hit, rq, "snoop shared", 64'(snp_shared), 64'(hit));
    chk(snp_dirty == dirty, rq, "snoop dirty", 64'(snp_dirty), 64'(dirty));
    if (dirty) begin
      chk(snp_data == mdat[ix], rq, "snoop data", snp_data, mdat[ix]);
      mem[la]  = snp_data;
      emem[la] = mdat[ix];
    end
    if (hit) mst[ix] = (c == 2'd0) ? 1 : 0;
    other[la] = 1;
    @(posedge clk); #1;
    snp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R12 watchdog expired act=%0d exp=%0d", 100000, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      for (int k = 0; k < 8; k++) mem[i][k*8 +: 8] = 8'(i * 8 * 7 + k * 7 + 3);
      emem[i]  = mem[i];
      other[i] = 0;
    end
    for (int i = 0; i < 8; i++) begin mst[i] = 0; mtag[i] = '0; mdat[i] = '0; end
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    bus_done = 0; bus_shared = 0; bus_rdata = '0;
    snp_valid = 0; snp_cmd = '0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk(!bus_req && !cpu_ack && !cpu_busy, "R1", "idle after reset",
        64'({bus_req, cpu_ack, cpu_busy}), 64'd0);

    cpu_op(0, 10'h008, 8'h00, "R1");    // first access misses, fills exclusive (R2)
    cpu_op(0, 10'h00C, 8'h00, "R2");    // hit
    cpu_op(1, 10'h009, 8'hA5, "R4");    // silent upgrade to modified
    snoop(2'd0, 7'h01, "R9");           // dirty read snoop, drops to shared
    cpu_op(1, 10'h00A, 8'h3C, "R5");    // shared write: invalidate first
    snoop(2'd1, 7'h01, "R10");          // read-exclusive snoop invalidates
    cpu_op(0, 10'h00B, 8'h00, "R10");   // misses again

    other[7'h02] = 1;
    cpu_op(0, 10'h010, 8'h00, "R3");    // shared fill
    cpu_op(1, 10'h011, 8'h77, "R3");    // invalidate proves shared state
    snoop(2'd0, 7'h7F, "R11");          // tag mismatch on index 7
    snoop(2'd0, 7'h0A, "R11");          // tag mismatch on index 2
    cpu_op(1, 10'h012, 8'h11, "R11");   // still modified: silent

    cpu_op(1, 10'h020, 8'h5A, "R6");    // write miss
    cpu_op(0, 10'h0A0, 8'h00, "R7");    // dirty victim on index 4
    cpu_op(0, 10'h048, 8'h00, "R8");    // clean victim on index 1

    other[7'h23] = 1;
    cpu_op(0, 10'h118, 8'h00, "R3");
    snoop(2'd2, 7'h23, "R10");          // invalidate snoop on shared line
    cpu_op(0, 10'h119, 8'h00, "R10");

    // same-index collision: snoop first, request one cycle later
    begin
      logic [7:0] exp_b;
      cur_rq = "R12";
      @(negedge clk);
      cpu_req = 1; cpu_we = 0; cpu_addr = 10'h049;
      snp_valid = 1; snp_cmd = 2'd0; snp_addr = 7'h09;
      #2;
      chk(!cpu_ack && cpu_busy, "R12", "collision stalls", 64'(cpu_ack), 64'd0);
      chk(snp_shared && !snp_dirty, "R9", "collision snoop result",
          64'({snp_shared, snp_dirty}), 64'd2);
      mst[1] = 1; other[7'h09] = 1;
      exp_b = mdat[1][8 +: 8];
      @(posedge clk); #1;
      snp_valid = 0;
      @(negedge clk); #2;
      chk(cpu_ack, "R12", "collision request completes next cycle", 64'(cpu_ack), 64'd1);
      chk(cpu_rdata == exp_b, "R12", "collision read data", 64'(cpu_rdata), 64'(exp_b));
      @(posedge clk); #1;
      cpu_req = 0;
    end
    cpu_op(1, 10'h04F, 8'hC3, "R9");    // line now shared: invalidate

    for (int k = 0; k < 40; k++) begin
      logic [9:0] a;
      a = 10'((k * 173 + 29) % 1024);
      other[a[9:3]] = k[1];
      cpu_op(k[0] ^ k[2], a, 8'(k * 13), "R7");
      if (k % 9 == 4) snoop(2'(k % 3), a[9:3], "R10");
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule